// File: doc/BRIEF.md
# Five-Channel Timer Register Front End

This block is the memory-mapped register face of a group of five timer channels. A simple 32-bit bus with a select strobe, a write flag, a byte address and write data reaches it. The block decodes the address to one of three per-channel registers: control, initial count or live count. It also holds a shared expiry status register and a fixed watchdog control word. The counting itself happens in separate channel blocks. This block hands them one-cycle write strobes with the bus data, and reads back their control, initial-count and live-count values.

Each channel raises a one-cycle expiry pulse, which sets that channel's bit in the status register. Software clears status bits by writing ones to them. Each channel has one interrupt output. It is the AND of the channel's status bit and the interrupt-enable bit (bit 29) of that channel's control value. The output follows either input without a register in between.

Top module: `tmr_regfile`

## Requirements
- R1: A write to byte offset 0x00, 0x04, 0x20, 0x24 or 0x40 raises `ch_ctrl_we` bit 0, 1, 2, 3 or 4 for that cycle only, with `ch_wdata` equal to the bus data. A read there returns that channel's `ch_ctrl_rd` word.
- R2: A write to 0x08, 0x0C, 0x28, 0x2C or 0x48 raises `ch_init_we` bit 0 to 4 in the same way. A read returns that channel's `ch_init_rd` word.
- R3: A read of 0x10, 0x14, 0x30, 0x34 or 0x50 returns the live count `ch_count` of channel 0 to 4. A write there raises no strobe.
- R4: Status register at 0x18, bits 4:0, one per channel. An expiry pulse sets its bit at the next clock edge. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. If a set and a clear reach the same bit in one cycle, the set wins.
- R5: `irq[i]` is high exactly when status bit i is set and bit 29 of `ch_ctrl_rd` word i is set. It changes in the same cycle as either input.
- R6: A read of 0x1C returns 0x00000400. Writes to 0x1C change nothing.
- R7: A read of an unmapped offset, an offset whose two low bits are not zero, or any offset at 0x60 or above returns zero. A write to such an offset raises no strobe and changes no state.
- R8: Read data is registered. It is valid on `bus_rdata` in the cycle after the read strobe and holds until the next read.
- R9: While reset is asserted, the status register is zero, every `irq` bit is low and `bus_rdata` is zero.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | AW | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ch_ctrl_we | output | 5 | Per-channel control write strobe |
| ch_init_we | output | 5 | Per-channel initial-count write strobe |
| ch_wdata | output | 32 | Data for the channel strobes |
| ch_ctrl_rd | input | 160 | Control words, channel i at bits 32i+31:32i |
| ch_init_rd | input | 160 | Initial-count words, same packing |
| ch_count | input | 160 | Live counts, same packing |
| ch_expire | input | 5 | One-cycle expiry pulses |
| irq | output | 5 | Per-channel interrupt lines |

## Verification
The bench sweeps every byte offset from 0x00 to 0x63 for both writes and reads. A decoder that folds the interleaved groups together, or ignores the low address bits, would show a strobe or data from the wrong channel at a gap offset such as 0x38, 0x44 or 0x06. It drives an expiry pulse and a clear to the same bit in one cycle. A design that gives the clear priority would lose that event and read back a zero bit. It also toggles interrupt enables while status bits are pending. A registered or stale enable would leave `irq` wrong for a cycle. Finally, it writes to the watchdog and live-count offsets and then reads them back, which exposes any storage that should not exist.

// File: rtl/tmr_regfile.sv
module tmr_regfile #(
  parameter int AW       = 12,
  parameter int NCH      = 5,
  parameter int IE_BIT   = 29,
  parameter logic [31:0] WDOG_INIT = 32'h0000_0400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NCH-1:0]    ch_ctrl_we,
  output logic [NCH-1:0]    ch_init_we,
  output logic [31:0]       ch_wdata,
  input  logic [NCH*32-1:0] ch_ctrl_rd,
  input  logic [NCH*32-1:0] ch_init_rd,
  input  logic [NCH*32-1:0] ch_count,
  input  logic [NCH-1:0]    ch_expire,
  output logic [NCH-1:0]    irq
);

  // Offsets group as blocks of eight words; within a block, word pairs are
  // (ctrl, init, count, misc) and the low word bit selects the odd channel.
  logic [1:0] blk;
  logic [2:0] wrd;
  logic [1:0] kind;
  logic [2:0] chn;
  logic       in_range, mapped, is_sts, is_wdg;
  logic [NCH-1:0] sts, ie;
  logic [31:0] rd_mux;

  assign blk      = bus_addr[6:5];
  assign wrd      = bus_addr[4:2];
  assign kind     = wrd[2:1];
  assign chn      = {blk, 1'b0} + {2'b00, wrd[0]};
  assign in_range = (bus_addr[1:0] == 2'b00) && (bus_addr[AW-1:7] == '0);
  assign is_sts   = in_range && blk == 2'd0 && wrd == 3'd6;
  assign is_wdg   = in_range && blk == 2'd0 && wrd == 3'd7;

  always_comb begin
    unique case (blk)
      2'd0:    mapped = in_range && kind != 2'd3;
      2'd1:    mapped = in_range && kind != 2'd3;
      2'd2:    mapped = in_range && kind != 2'd3 && !wrd[0];
      default: mapped = 1'b0;
    endcase
  end

  always_comb begin
    ch_ctrl_we = '0;
    ch_init_we = '0;
    if (bus_sel && bus_wr && mapped) begin
      if (kind == 2'd0) ch_ctrl_we[chn] = 1'b1;
      if (kind == 2'd1) ch_init_we[chn] = 1'b1;
    end
  end
  assign ch_wdata = bus_wdata;

  always_comb begin
    rd_mux = '0;
    if (is_sts)      rd_mux = {{(32-NCH){1'b0}}, sts};
    else if (is_wdg) rd_mux = WDOG_INIT;
    else if (mapped) begin
      case (kind)
        2'd0:    rd_mux = ch_ctrl_rd[32*chn +: 32];
        2'd1:    rd_mux = ch_init_rd[32*chn +: 32];
        default: rd_mux = ch_count[32*chn +: 32];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 bus_rdata <= '0;
    else if (bus_sel && !bus_wr) bus_rdata <= rd_mux;

  logic [NCH-1:0] sts_clr;
  assign sts_clr = (bus_sel && bus_wr && is_sts) ? bus_wdata[NCH-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sts <= '0;
    else        sts <= (sts & ~sts_clr) | ch_expire;

  for (genvar i = 0; i < NCH; i++) begin : g_ie
    assign ie[i] = ch_ctrl_rd[32*i + IE_BIT];
  end

  assign irq = sts & ie;

endmodule

module tmr_regfile_chk #(
  parameter int AW     = 12,
  parameter int NCH    = 5,
  parameter int IE_BIT = 29
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [31:0]       bus_rdata,
  input logic [NCH-1:0]    ch_ctrl_we,
  input logic [NCH-1:0]    ch_init_we,
  input logic [NCH*32-1:0] ch_ctrl_rd,
  input logic [NCH-1:0]    ch_expire,
  input logic [NCH-1:0]    irq
);
  logic [NCH-1:0] ie_v;
  always_comb
    for (int i = 0; i < NCH; i++) ie_v[i] = ch_ctrl_rd[32*i + IE_BIT];

  a_r1_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ch_ctrl_we, ch_init_we}));
  a_r7_strobe_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    ({ch_ctrl_we, ch_init_we} != '0) |-> (bus_sel && bus_wr));
  a_r4_expire_reaches_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_expire != '0) |=> (((irq | ~ie_v) & $past(ch_expire)) == $past(ch_expire)));
  a_r5_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (irq & ~ie_v) == '0);
  a_r8_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_wr) |=> $stable(bus_rdata));
  always @(posedge clk)
    if (!rst_n) a_r9_reset_quiet: assert (irq == '0 && bus_rdata == '0);
endmodule

bind tmr_regfile tmr_regfile_chk #(.AW(AW), .NCH(NCH), .IE_BIT(IE_BIT)) u_chk (.*);

// File: tb/sim_tmr_regfile.sv
module sim_tmr_regfile;
  logic         clk = 0, rst_n = 0;
  logic         bus_sel = 0, bus_wr = 0;
  logic [11:0]  bus_addr = '0;
  logic [31:0]  bus_wdata = '0, bus_rdata, ch_wdata;
  logic [4:0]   ch_ctrl_we, ch_init_we, irq;
  logic [4:0]   ch_expire = '0, ie = '0;
  logic [159:0] ch_ctrl_rd, ch_init_rd, ch_count;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  function automatic logic [31:0] ctrlv(int c);
    return 32'h0A00_0000 + c | (ie[c] ? 32'h2000_0000 : 32'h0);
  endfunction
  function automatic logic [31:0] initv(int c); return 32'h5500_0000 + c * 17; endfunction
  function automatic logic [31:0] cntv(int c);  return 32'h0033_0000 + c * 3;  endfunction

  always_comb
    for (int c = 0; c < 5; c++) begin
      ch_ctrl_rd[32*c +: 32] = ctrlv(c);
      ch_init_rd[32*c +: 32] = initv(c);
      ch_count[32*c +: 32]   = cntv(c);
    end

  tmr_regfile u0 (.*);

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  // kind: 0 ctrl, 1 init, 2 count, 3 status, 4 watchdog, 5 unmapped; c = channel
  function automatic void classify(int a, output int kind, output int c);
    int w, b, wd;
    kind = 5; c = 0;
    if (a % 4 != 0 || a >= 'h60) return;
    w = a / 4; b = w / 8; wd = w % 8;
    c = b * 2 + wd % 2;
    if (b == 0 && wd == 6) kind = 3;
    else if (b == 0 && wd == 7) kind = 4;
    else if (wd / 2 == 3) kind = 5;
    else if (b == 2 && wd % 2 == 1) kind = 5;
    else kind = wd / 2;
  endfunction

  task automatic do_rd(int a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = 12'(a);
    @(negedge clk); bus_sel = 0; d = bus_rdata;
  endtask

  task automatic do_wr(int a, logic [31:0] d, output logic [4:0] cwe, output logic [4:0] iwe);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = 12'(a); bus_wdata = d;
    #1; cwe = ch_ctrl_we; iwe = ch_init_we;
    if (ch_ctrl_we != 0 || ch_init_we != 0) chk("R1 wdata", ch_wdata, d);
    @(negedge clk); bus_sel = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog timeout act=running exp=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [4:0] cwe, iwe;
    int kind, c;
    #5;
    chk("R9 reset irq", {27'b0, irq}, 0);
    chk("R9 reset rdata", bus_rdata, 0);
    repeat (2) @(negedge clk);
    rst_n = 1;

    // write sweep: strobes, incl. read-only and unmapped (R1 R2 R3 R6 R7)
    for (int a = 0; a < 'h64; a++) begin
      do_wr(a, 32'hFFFF_FFE0 | a, cwe, iwe);
      classify(a, kind, c);
      chk($sformatf("R1 ctrl_we @%h", a), {27'b0, cwe}, kind == 0 ? 32'(1 << c) : 0);
      chk($sformatf("R2 init_we @%h", a), {27'b0, iwe}, kind == 1 ? 32'(1 << c) : 0);
    end

    // read sweep (R1 R2 R3 R6 R7)
    ie = 5'b01011;
    for (int a = 0; a < 'h64; a++) begin
      logic [31:0] e;
      do_rd(a, d);
      classify(a, kind, c);
      case (kind)
        0: e = ctrlv(c);
        1: e = initv(c);
        2: e = cntv(c);
        3: e = 0;
        4: e = 32'h400;
        default: e = 0;
      endcase
      chk($sformatf("R%0s rd @%h", kind == 0 ? "1" : kind == 1 ? "2" : kind == 2 ? "3" :
          kind == 4 ? "6" : "7", a), d, e);
    end

    // R8 hold: a write and idle cycles leave rdata unchanged
    do_rd('h14, d);
    do_wr('h1C, 32'h1234, cwe, iwe);
    repeat (3) @(negedge clk);
    chk("R8 hold", bus_rdata, cntv(1));

    // R4 expire sets status; R5 irq gating
    @(negedge clk); ch_expire = 5'b10101;
    @(negedge clk); ch_expire = 0;
    #1 chk("R5 irq gated", {27'b0, irq}, 5'b10101 & ie);
    do_rd('h18, d);
    chk("R4 status set", d, 5'h15);
    ie = 5'b11111; #1;
    chk("R5 irq follows enable", {27'b0, irq}, 5'h15);
    ie = 5'b00000; #1;
    chk("R5 irq drops with enable", {27'b0, irq}, 0);
    ie = 5'b11111;
    do_wr('h18, 32'h05, cwe, iwe);
    do_rd('h18, d);
    chk("R4 w1c", d, 5'h10);
    #1 chk("R5 irq after clear", {27'b0, irq}, 5'h10);

    // R4 set beats clear in same cycle
    @(negedge clk); ch_expire = 5'b00010;
    bus_sel = 1; bus_wr = 1; bus_addr = 'h18; bus_wdata = 32'h12;
    @(negedge clk); ch_expire = 0; bus_sel = 0;
    do_rd('h18, d);
    chk("R4 set wins", d, 5'h02);

    // R6 watchdog after writes
    do_rd('h1C, d);
    chk("R6 watchdog fixed", d, 32'h400);

    // R9 reset mid-run clears status
    @(negedge clk); rst_n = 0; #1;
    chk("R9 irq in reset", {27'b0, irq}, 0);
    @(negedge clk); rst_n = 1;
    do_rd('h18, d);
    chk("R9 status cleared", d, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule